// File: doc/BRIEF.md
# Serial Front End for an Eight-Channel Low-Side Switch

This block is the serial command and diagnostic port of an eight-channel low-side switch controller. A host acts as SPI master and uses it in mode 1 (clock idles low, slave drives on the rising edge, slave samples on the falling edge). When chip select falls, the block loads an 8-bit diagnostic word from the fault logic into its shift register. It then drives the most significant bit on the serial output. While the frame lasts, command bits move in on the serial input and diagnostic bits move out, both most significant bit first. When chip select rises, the received byte is written to the channel latch. In the same cycle a one-cycle request goes to the fault logic to clear its diagnostic register.

The three SPI pins have no timing relation to the system clock. Each passes through a two-stage synchronizer, and edges are found in the system clock domain. The system clock must therefore run at least four times faster than the serial clock. If a frame carries more than eight clocks, the bits pass through to the serial output, so the device can sit in a daisy chain. Only the last eight bits received are committed. If a frame carries no serial clock pulse at all, it changes nothing. The serial output is given as a data bit plus an output enable, which a pad cell turns into a tri-state pin.

Top module: `octal_switch_spi`

## Requirements
- R1: While `rst_n` is low, `chan_on` is 0 at once (asynchronously), and `spi_sdo_oe`, `spi_sdo` and `diag_clr` are 0. After release the block is idle with all channels off.
- R2: On a falling `spi_csn`, `spi_sdo_oe` goes high and `spi_sdo` shows `diag_in[7]`. Both take effect on the third rising system-clock edge after the pin change, and `diag_in` is sampled on that edge.
- R3: `spi_sdi` is sampled at falling serial-clock edges, first bit = bit 7. After an 8-clock frame, `chan_on[i]` equals received bit i: bit 7 drives channel 8, bit 0 drives channel 1, and 1 means on.
- R4: `spi_sdo` changes only on rising serial-clock edges, on chip-select edges or in reset. The rising clocks of a frame present the diagnostic word from bit 7 down to bit 0, then the received bits in arrival order.
- R5: While `spi_csn` is high, `spi_sclk` and `spi_sdi` have no effect, and `spi_sdo_oe` and `spi_sdo` are 0.
- R6: A rising `spi_csn` that ends a frame with at least one complete serial-clock pulse updates `chan_on` and raises `diag_clr` for exactly one system-clock cycle. Both change on the same edge, the third after the pin change.
- R7: A rising `spi_csn` that ends a frame with no serial-clock pulse leaves `chan_on` unchanged and raises no `diag_clr`.
- R8: In a frame of N > 8 clocks, the last 8 bits received are committed. The bit shown at rising clock 8+k is the k-th bit received.
- R9: In a frame of N < 8 clocks, the committed byte is the diagnostic word shifted left by N, with the N received bits in the low positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low, asynchronous |
| spi_sclk | input | 1 | Serial clock, idles low, asynchronous |
| spi_sdi | input | 1 | Serial command data in |
| diag_in | input | 8 | Diagnostic word from the fault logic, bit i for channel i+1 |
| spi_sdo | output | 1 | Serial diagnostic data out |
| spi_sdo_oe | output | 1 | Output enable for the serial-out pad |
| chan_on | output | 8 | Channel latch, 1 = channel on |
| diag_clr | output | 1 | One-cycle request to clear the diagnostic register |

## Verification
A corrupted shift register shows up on `spi_sdo` by the next rising serial clock, and on `chan_on` when the frame ends. A stale frame-active flag or a stale clock-seen flag shows up as a wrong output enable, or as a commit that should not happen (or one that is missing), three system cycles after the chip-select change. The bench runs a reference model that predicts every output on every system cycle, so a divergence is reported in the cycle it first appears. Directed frames of 0, 3, 8 and 12 clocks, and clock activity while deselected, cover the commit and pass-through cases.

// File: rtl/osw_pkg.sv
package osw_pkg;
  localparam int OSW_NCH = 8;
  localparam int OSW_SYNC_STAGES = 2;
  typedef logic [OSW_NCH-1:0] chan_vec_t;
endpackage

// File: rtl/osw_sync.sv
module osw_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/osw_edge.sv
module osw_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_det
    assign rise[i] = lvl[i] & ~prev_q[i];
    assign fall[i] = ~lvl[i] & prev_q[i];
  end
endmodule

// File: rtl/osw_frame.sv
module osw_frame #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_fall,
  input  logic           cs_rise,
  input  logic           sck_rise,
  input  logic           sck_fall,
  input  logic           sdi,
  input  logic [NCH-1:0] diag,
  output logic           sdo,
  output logic           sdo_oe,
  output logic [NCH-1:0] word,
  output logic           commit
);
  localparam int MSB = NCH - 1;

  logic [NCH-1:0] sreg_q, sreg_n;
  logic           so_q, so_n;
  logic           act_q, act_n;
  logic           seen_q, seen_n;

  always_comb begin
    sreg_n = sreg_q;
    so_n   = so_q;
    act_n  = act_q;
    seen_n = seen_q;
    commit = 1'b0;
    if (cs_fall) begin
      sreg_n = diag;
      so_n   = diag[MSB];
      act_n  = 1'b1;
      seen_n = 1'b0;
    end else if (cs_rise) begin
      commit = act_q & seen_q;
      act_n  = 1'b0;
      so_n   = 1'b0;
      seen_n = 1'b0;
    end else if (act_q) begin
      if (sck_fall) begin
        sreg_n = {sreg_q[MSB-1:0], sdi};
        seen_n = 1'b1;
      end
      if (sck_rise) so_n = sreg_q[MSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      so_q   <= 1'b0;
      act_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      sreg_q <= sreg_n;
      so_q   <= so_n;
      act_q  <= act_n;
      seen_q <= seen_n;
    end
  end

  assign sdo    = so_q;
  assign sdo_oe = act_q;
  assign word   = sreg_q;
endmodule

// File: rtl/octal_switch_spi.sv
module octal_switch_spi
  import osw_pkg::*;
#(
  parameter int NCH = OSW_NCH,
  parameter int SYNC_STAGES = OSW_SYNC_STAGES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spi_csn,
  input  logic           spi_sclk,
  input  logic           spi_sdi,
  input  logic [NCH-1:0] diag_in,
  output logic           spi_sdo,
  output logic           spi_sdo_oe,
  output logic [NCH-1:0] chan_on,
  output logic           diag_clr
);
  localparam int PINS = 3;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic [PINS-1:0] pin_s;
  logic            cs_s, sck_s, sdi_s;

  osw_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d({spi_csn, spi_sclk, spi_sdi}), .q(pin_s)
  );
  assign cs_s  = pin_s[2];
  assign sck_s = pin_s[1];
  assign sdi_s = pin_s[0];

  logic [1:0] lvl_rise, lvl_fall;
  logic       cs_fall_w, cs_rise_w, sck_rise_g, sck_fall_g;

  osw_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_i_n), .lvl({cs_s, sck_s}), .rise(lvl_rise), .fall(lvl_fall)
  );
  assign cs_fall_w  = lvl_fall[1];
  assign cs_rise_w  = lvl_rise[1];
  assign sck_rise_g = lvl_rise[0] & ~cs_s;
  assign sck_fall_g = lvl_fall[0] & ~cs_s;

  logic [NCH-1:0] frame_word;
  logic           commit_w;

  osw_frame #(.NCH(NCH)) u_frame (
    .clk(clk), .rst_n(rst_i_n),
    .cs_fall(cs_fall_w), .cs_rise(cs_rise_w),
    .sck_rise(sck_rise_g), .sck_fall(sck_fall_g),
    .sdi(sdi_s), .diag(diag_in),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe),
    .word(frame_word), .commit(commit_w)
  );

  // channel latch and clear request
  logic [NCH-1:0] chan_n;

  always_comb begin
    chan_n = chan_on;
    if (commit_w) chan_n = frame_word;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      chan_on  <= '0;
      diag_clr <= 1'b0;
    end else begin
      chan_on  <= chan_n;
      diag_clr <= commit_w;
    end
  end
endmodule

// File: rtl/osw_chk.sv
module osw_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sdo,
  input logic           sdo_oe,
  input logic [NCH-1:0] chan_on,
  input logic           diag_clr,
  input logic           ev_sck_rise,
  input logic           ev_cs_fall,
  input logic           ev_cs_rise
);
  // R2
  oe_on_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cs_fall |=> sdo_oe);

  // R5
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R4
  sdo_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(ev_sck_rise || ev_cs_fall || ev_cs_rise));

  // R6
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diag_clr |=> !diag_clr);

  // R7
  latch_with_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_on) |-> diag_clr);
endmodule

bind octal_switch_spi osw_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(spi_sdo), .sdo_oe(spi_sdo_oe),
  .chan_on(chan_on), .diag_clr(diag_clr),
  .ev_sck_rise(sck_rise_g), .ev_cs_fall(cs_fall_w), .ev_cs_rise(cs_rise_w)
);

// File: tb/octal_switch_spi_bench.sv
module octal_switch_spi_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_csn, spi_sclk, spi_sdi;
  logic [7:0] diag_in;
  logic       spi_sdo, spi_sdo_oe, diag_clr;
  logic [7:0] chan_on;

  int n_chk = 0;
  int n_fail = 0;
  int clr_cnt = 0;

  always #4 clk = ~clk;

  octal_switch_spi u_octal_switch_spi (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .spi_sdi(spi_sdi), .diag_in(diag_in), .spi_sdo(spi_sdo),
    .spi_sdo_oe(spi_sdo_oe), .chan_on(chan_on), .diag_clr(diag_clr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic m_r1, m_r2;
  logic m_cs1, m_cs2, m_csd, m_sk1, m_sk2, m_skd, m_si1, m_si2;
  bit   m_bits[$];
  logic e_sdo, e_oe, e_clr, e_seen;
  logic [7:0] e_chan;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      m_cs1 = 1; m_cs2 = 1; m_csd = 1;
      m_sk1 = 0; m_sk2 = 0; m_skd = 0; m_si1 = 0; m_si2 = 0;
      m_bits.delete();
      for (int i = 0; i < 8; i++) m_bits.push_back(1'b0);
      e_sdo = 0; e_oe = 0; e_clr = 0; e_seen = 0; e_chan = 8'h00;
    end else begin
      if (m_r2) begin
        bit cf, cr, sr, sf;
        cf = m_csd && !m_cs2;
        cr = !m_csd && m_cs2;
        sr = !m_cs2 && m_sk2 && !m_skd;
        sf = !m_cs2 && !m_sk2 && m_skd;
        e_clr = 0;
        if (cf) begin
          m_bits.delete();
          for (int i = 7; i >= 0; i--) m_bits.push_back(diag_in[i]);
          e_sdo = diag_in[7]; e_oe = 1; e_seen = 0;
        end else if (cr) begin
          if (e_seen && e_oe) begin
            for (int i = 0; i < 8; i++) e_chan[i] = m_bits[7-i];
            e_clr = 1;
          end
          e_oe = 0; e_sdo = 0; e_seen = 0;
        end else if (e_oe) begin
          if (sf) begin
            m_bits.push_back(m_si2);
            void'(m_bits.pop_front());
            e_seen = 1;
          end
          if (sr) e_sdo = m_bits[0];
        end
        m_csd = m_cs2; m_skd = m_sk2;
        m_cs2 = m_cs1; m_sk2 = m_sk1; m_si2 = m_si1;
        m_cs1 = spi_csn; m_sk1 = spi_sclk; m_si1 = spi_sdi;
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  always @(negedge clk) begin
    #1;
    chk("R3 chan_on vs model", {24'h0, chan_on}, {24'h0, e_chan});
    chk("R2 sdo_oe vs model", {31'h0, spi_sdo_oe}, {31'h0, e_oe});
    chk("R4 sdo vs model", {31'h0, spi_sdo}, {31'h0, e_sdo});
    chk("R6 diag_clr vs model", {31'h0, diag_clr}, {31'h0, e_clr});
    if (diag_clr) clr_cnt++;
  end

  // ---------------- stimulus ----------------
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] bits, input int n, output logic [31:0] cap);
    cap = '0;
    spi_csn = 0;
    wait_clk(6);
    for (int i = 0; i < n; i++) begin
      spi_sclk = 1; spi_sdi = bits[n-1-i];
      wait_clk(5);
      cap = {cap[30:0], spi_sdo};
      spi_sclk = 0;
      wait_clk(5);
    end
    wait_clk(3);
    spi_csn = 1;
    wait_clk(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] cap;
    int c0;
    rst_n = 0; spi_csn = 1; spi_sclk = 0; spi_sdi = 0; diag_in = 8'h00;
    wait_clk(5);
    // R1 reset state
    chk("R1 chan off in reset", {24'h0, chan_on}, 32'h0);
    chk("R1 oe low in reset", {31'h0, spi_sdo_oe}, 32'h0);
    rst_n = 1;
    wait_clk(6);
    chk("R1 idle after release", {23'h0, spi_sdo_oe, chan_on}, 32'h0);

    // R2 R3 R4 R6: full frame
    diag_in = 8'hA5; c0 = clr_cnt;
    frame(32'h3C, 8, cap);
    chk("R3 commit 8-bit frame", {24'h0, chan_on}, 32'h3C);
    chk("R4 diag shifted out msb first", cap & 32'hFF, 32'hA5);
    chk("R6 one clear pulse", clr_cnt - c0, 1);

    // R7: frame without clocks
    c0 = clr_cnt;
    spi_csn = 0; wait_clk(10); spi_csn = 1; wait_clk(6);
    chk("R7 no-clock frame keeps latch", {24'h0, chan_on}, 32'h3C);
    chk("R7 no-clock frame no clear", clr_cnt - c0, 0);

    // R5: activity while deselected
    c0 = clr_cnt;
    for (int k = 0; k < 5; k++) begin
      spi_sclk = 1; spi_sdi = ~spi_sdi; wait_clk(5);
      chk("R5 oe low while deselected", {31'h0, spi_sdo_oe}, 32'h0);
      chk("R5 sdo low while deselected", {31'h0, spi_sdo}, 32'h0);
      spi_sclk = 0; wait_clk(5);
    end
    chk("R5 latch untouched", {24'h0, chan_on}, 32'h3C);
    chk("R5 no clear", clr_cnt - c0, 0);

    // R8: daisy chain, 12 clocks
    diag_in = 8'h96;
    frame(32'hF81, 12, cap);
    chk("R8 last eight committed", {24'h0, chan_on}, 32'h81);
    chk("R8 diag first on sdo", (cap >> 4) & 32'hFF, 32'h96);
    chk("R8 received bits passed through", cap & 32'hF, 32'hF);

    // R9: short frame, 3 clocks
    diag_in = 8'h5A;
    frame(32'h5, 3, cap);
    chk("R9 partial shift commit", {24'h0, chan_on}, 32'hD5);
    chk("R2 first bit is diag msb", cap & 32'h7, 32'h2);

    // R1: reset mid-operation clears latch at once
    @(negedge clk);
    rst_n = 0;
    #1;
    chk("R1 async clear of channels", {24'h0, chan_on}, 32'h0);
    wait_clk(3);
    rst_n = 1;
    wait_clk(6);
    chk("R1 channels off after reset", {24'h0, chan_on}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule